// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block evaluates a set of sum-of-products functions whose structure is loaded at run time. It has two programmable planes. In the product plane, each row describes one product term. For every input, that row holds a two-bit literal code: use the input as it is, use its complement, or leave the input out. In the sum plane, each row belongs to one output and holds one select bit per product term. An output is the OR of the product terms it selects. A product term can therefore feed any number of outputs.

The path from the inputs to the outputs has no register in it. The only state is the two planes. They are loaded through a synchronous port that writes one whole row per clock edge while the write enable is high. After reset, every literal is set to "leave out" and every select bit is clear, so all outputs read 0 until rows are loaded.

Top module: `sop_logic_array`

## Requirements
- R1: While reset is asserted and after it is released, every literal code reads 00 and every sum-plane bit reads 0, so every output is 0 for any input value.
- R2: The literal for input i sits at bits [2i+1:2i] of a product row. Code 10 passes the input unchanged. Code 01 passes its complement. Code 00 leaves the input out. Code 11 is reserved and also leaves the input out.
- R3: A product term whose literals all leave their inputs out evaluates to 1. An output that selects such a term is 1 for every input value.
- R4: An output whose sum-plane row is all zero is 0 for every input value.
- R5: Output j is 1 exactly when at least one product term t, with bit t of sum row j set to 1, evaluates to 1. One term can drive several outputs at the same time.
- R6: A rising clock edge with `cfg_we` high loads `cfg_data` into row `cfg_row` of the plane picked by `cfg_plane`. The value 0 picks the product plane and uses data bits [2*N_IN-1:0]. The value 1 picks the sum plane and uses data bits [N_TERM-1:0]. The outputs show the new row from that edge on, and not before it.
- R7: A clock edge with `cfg_we` low changes no row. A write whose row index is not below the row count of the selected plane (N_TERM rows for the product plane, N_OUT rows for the sum plane) also changes no row.
- R8: A change on `in_vec` reaches `f_out` without waiting for a clock edge.
- R9: Loading a 3-input, 5-term table gives F0 = A'B' + AC', F1 = AC' + B, F2 = A'B' + BC' and F3 = BC' + B. Loading a 4-input table gives F1 = a'bd + abd + ab'c' + b'c, F2 = c + a'bd and F3 = bc + ab'c' + abd. Both use shared product terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset that clears both planes |
| cfg_we | input | 1 | Row write enable, sampled on the rising edge |
| cfg_plane | input | 1 | Plane select: 0 = product plane, 1 = sum plane |
| cfg_row | input | ROW_W | Index of the row to write |
| cfg_data | input | DATA_W | Row contents (literal codes or select bits) |
| in_vec | input | N_IN | Function inputs |
| f_out | output | N_OUT | Function outputs, combinational from in_vec |

## Verification
Two things can happen in the same cycle: evaluation of a new input pattern and a row write that changes the function being evaluated. The bench provokes this by driving a fresh `in_vec` together with a write at the same falling edge, with writes, planes, rows and data drawn at random. The output is judged twice. First, before the rising edge, it is compared against the bench's table as it was before the write. Then, just after the edge, it is compared against the updated table for the same input. A row index that is out of range for its plane is included in the draws, so the bench can confirm that such a write leaves both readings unchanged.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    LIT_DROP = 2'b00,
    LIT_NEG  = 2'b01,
    LIT_POS  = 2'b10,
    LIT_RSV  = 2'b11
  } lit_code_e;

  // Contribution of one literal to a product term.
  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    case (lit_code_e'(code))
      LIT_POS: return x;
      LIT_NEG: return ~x;
      default: return 1'b1;
    endcase
  endfunction

  // True when the literal code leaves its input out of the term.
  function automatic logic lit_is_drop(input logic [1:0] code);
    return (code == LIT_DROP) || (code == LIT_RSV);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sop_cfg_decode.sv
module sop_cfg_decode #(
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned ROW_W  = 3
) (
  input  logic             we,
  input  logic             plane,
  input  logic [ROW_W-1:0] row,
  output logic [N_TERM-1:0] and_wen,
  output logic [N_OUT-1:0]  or_wen
);

  logic and_sel;
  logic or_sel;

  assign and_sel = we & ~plane;
  assign or_sel  = we &  plane;

  // One compare per row; an index beyond the plane matches no row.
  for (genvar t = 0; t < N_TERM; t++) begin : g_and_dec
    assign and_wen[t] = and_sel && (int'(row) == t);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_or_dec
    assign or_wen[j] = or_sel && (int'(row) == j);
  end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8,
  localparam int unsigned ROW_BITS = 2 * N_IN
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_TERM-1:0]          wen,
  input  logic [ROW_BITS-1:0]        wdata,
  input  logic [N_IN-1:0]            in_vec,
  output logic [N_TERM-1:0]          term_vec,
  output logic [N_TERM*ROW_BITS-1:0] rows_flat
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [ROW_BITS-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (wen[t]) begin
        row_q <= wdata;
      end
    end

    // AND of every literal in the row.
    always_comb begin
      logic acc;
      acc = 1'b1;
      for (int i = 0; i < int'(N_IN); i++) begin
        acc = acc & lit_pass(row_q[2*i +: 2], in_vec[i]);
      end
      term_vec[t] = acc;
    end

    assign rows_flat[t*ROW_BITS +: ROW_BITS] = row_q;
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_OUT-1:0]          wen,
  input  logic [N_TERM-1:0]         wdata,
  input  logic [N_TERM-1:0]         term_vec,
  output logic [N_OUT-1:0]          f_out,
  output logic [N_OUT*N_TERM-1:0]   rows_flat
);

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
      end else if (wen[j]) begin
        sel_q <= wdata;
      end
    end

    assign f_out[j] = |(term_vec & sel_q);
    assign rows_flat[j*N_TERM +: N_TERM] = sel_q;
  end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4,
  localparam int unsigned ROW_W  = idx_width(max_u(N_TERM, N_OUT)),
  localparam int unsigned DATA_W = max_u(2 * N_IN, N_TERM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_plane,
  input  logic [ROW_W-1:0]  cfg_row,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  f_out
);

  localparam int unsigned AND_BITS = 2 * N_IN;

  // Named internal events, visible to the bound checker.
  logic [N_TERM-1:0]          and_wen;
  logic [N_OUT-1:0]           or_wen;
  logic [N_TERM-1:0]          term_vec;
  logic [N_TERM*AND_BITS-1:0] and_rows_flat;
  logic [N_OUT*N_TERM-1:0]    or_rows_flat;

  sop_cfg_decode #(
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .ROW_W  (ROW_W)
  ) u_dec (
    .we      (cfg_we),
    .plane   (cfg_plane),
    .row     (cfg_row),
    .and_wen (and_wen),
    .or_wen  (or_wen)
  );

  sop_and_plane #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM)
  ) u_and (
    .clk       (clk),
    .rst_n     (rst_n),
    .wen       (and_wen),
    .wdata     (cfg_data[AND_BITS-1:0]),
    .in_vec    (in_vec),
    .term_vec  (term_vec),
    .rows_flat (and_rows_flat)
  );

  sop_or_plane #(
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT)
  ) u_or (
    .clk       (clk),
    .rst_n     (rst_n),
    .wen       (or_wen),
    .wdata     (cfg_data[N_TERM-1:0]),
    .term_vec  (term_vec),
    .f_out     (f_out),
    .rows_flat (or_rows_flat)
  );

endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk
  import sop_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_we,
  input logic                        cfg_plane,
  input logic [ROW_W-1:0]            cfg_row,
  input logic [DATA_W-1:0]           cfg_data,
  input logic [N_OUT-1:0]            f_out,
  input logic [N_TERM-1:0]           term_vec,
  input logic [N_TERM*2*N_IN-1:0]    and_rows_flat,
  input logic [N_OUT*N_TERM-1:0]     or_rows_flat
);

  // Last accepted sum-plane write, kept to compare with the stored row.
  logic              wr_or_q;
  logic [ROW_W-1:0]  wr_row_q;
  logic [N_TERM-1:0] wr_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_or_q   <= 1'b0;
      wr_row_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_or_q   <= cfg_we && cfg_plane && (int'(cfg_row) < int'(N_OUT));
      wr_row_q  <= cfg_row;
      wr_data_q <= cfg_data[N_TERM-1:0];
    end
  end

  logic [N_TERM-1:0] stored_sel;
  always_comb begin
    stored_sel = '0;
    for (int j = 0; j < int'(N_OUT); j++) begin
      if (int'(wr_row_q) == j) stored_sel = or_rows_flat[j*N_TERM +: N_TERM];
    end
  end

  // R1: reset leaves both planes clear and every output low
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (or_rows_flat == '0 && and_rows_flat == '0 && f_out == '0));

  // R6: an accepted sum-plane write is stored after the edge
  a_r6_or_row_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_or_q |-> (stored_sel == wr_data_q));

  // R7: without a write enable both planes hold
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(and_rows_flat) && $stable(or_rows_flat)));

  // R7: a row index beyond the sum plane writes nothing
  a_r7_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_plane && (int'(cfg_row) >= int'(N_OUT)))
      |=> ($stable(and_rows_flat) && $stable(or_rows_flat)));

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_chk
    // R4: an empty sum row forces its output low
    a_r4_empty_row_low: assert property (@(posedge clk) disable iff (!rst_n)
      (or_rows_flat[j*N_TERM +: N_TERM] == '0) |-> !f_out[j]);
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
    logic all_drop;
    always_comb begin
      all_drop = 1'b1;
      for (int i = 0; i < int'(N_IN); i++) begin
        all_drop = all_drop & lit_is_drop(and_rows_flat[t*2*N_IN + 2*i +: 2]);
      end
    end
    // R3: a term with every input left out is true
    a_r3_empty_term_true: assert property (@(posedge clk) disable iff (!rst_n)
      all_drop |-> term_vec[t]);
  end

endmodule

bind sop_logic_array sop_logic_array_chk #(
  .N_IN   (N_IN),
  .N_TERM (N_TERM),
  .N_OUT  (N_OUT),
  .ROW_W  (ROW_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_plane     (cfg_plane),
  .cfg_row       (cfg_row),
  .cfg_data      (cfg_data),
  .f_out         (f_out),
  .term_vec      (term_vec),
  .and_rows_flat (and_rows_flat),
  .or_rows_flat  (or_rows_flat)
);

// File: tb/sop_logic_array_tb.sv
`timescale 1ns/1ps
module sop_logic_array_tb_top;

  localparam int N_IN = 4, N_TERM = 8, N_OUT = 4, ROW_W = 3, DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_plane = 1'b0;
  logic [ROW_W-1:0]  cfg_row = '0;
  logic [DATA_W-1:0] cfg_data = '0;
  logic [N_IN-1:0]   in_vec = '0;
  logic [N_OUT-1:0]  f_out;

  int n_checks = 0;
  int n_fail = 0;

  logic [2*N_IN-1:0] m_and [N_TERM];
  logic [N_TERM-1:0] m_or  [N_OUT];

  always #5 clk = ~clk;

  sop_logic_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
    .cfg_row(cfg_row), .cfg_data(cfg_data), .in_vec(in_vec), .f_out(f_out)
  );

  // Bench model: literal codes as stated in R2.
  function automatic logic [N_OUT-1:0] model_eval(input logic [N_IN-1:0] v);
    logic [N_OUT-1:0] r;
    logic [N_TERM-1:0] p;
    for (int t = 0; t < N_TERM; t++) begin
      p[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (m_and[t][2*i +: 2] == 2'b10 && !v[i]) p[t] = 1'b0;
        if (m_and[t][2*i +: 2] == 2'b01 &&  v[i]) p[t] = 1'b0;
      end
    end
    for (int j = 0; j < N_OUT; j++) begin
      r[j] = 1'b0;
      for (int t = 0; t < N_TERM; t++) if (m_or[j][t] && p[t]) r[j] = 1'b1;
    end
    return r;
  endfunction

  // R9 reference formulas, A=in[2] B=in[1] C=in[0]
  function automatic logic [3:0] ex1(input logic [3:0] v);
    logic a, b, c;
    a = v[2]; b = v[1]; c = v[0];
    return {(b & ~c) | b, (~a & ~b) | (b & ~c), (a & ~c) | b, (~a & ~b) | (a & ~c)};
  endfunction

  // R9 reference formulas, a=in[3] b=in[2] c=in[1] d=in[0]; output 0 unused
  function automatic logic [3:0] ex2(input logic [3:0] v);
    logic a, b, c, d, f1, f2, f3;
    a = v[3]; b = v[2]; c = v[1]; d = v[0];
    f1 = (~a & b & d) | (a & b & d) | (a & ~b & ~c) | (~b & c);
    f2 = c | (~a & b & d);
    f3 = (b & c) | (a & ~b & ~c) | (a & b & d);
    return {f3, f2, f1, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [N_OUT-1:0] got,
                       input logic [N_OUT-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: in=%0h got %0h expected %0h", tag, in_vec, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_we = 1'b0;
    for (int t = 0; t < N_TERM; t++) m_and[t] = '0;
    for (int j = 0; j < N_OUT; j++) m_or[j] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic bit in_range(input logic plane, input logic [ROW_W-1:0] row);
    return plane ? (int'(row) < N_OUT) : (int'(row) < N_TERM);
  endfunction

  task automatic model_write(input logic plane, input logic [ROW_W-1:0] row,
                             input logic [DATA_W-1:0] data);
    if (in_range(plane, row)) begin
      if (plane) m_or[row] = data[N_TERM-1:0];
      else       m_and[row] = data[2*N_IN-1:0];
    end
  endtask

  task automatic write_row(input logic plane, input logic [ROW_W-1:0] row,
                           input logic [DATA_W-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_plane = plane; cfg_row = row; cfg_data = data;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    model_write(plane, row, data);
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << N_IN); v++) begin
      in_vec = v[N_IN-1:0];
      #1;
      check(tag, f_out, model_eval(in_vec));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R1: cleared planes give all-zero outputs
    for (int v = 0; v < 16; v++) begin
      in_vec = v[3:0]; #1;
      check("R1 reset", f_out, 4'h0);
    end

    // R3: output 0 selects untouched term 7 (all literals left out)
    write_row(1'b1, 3'd0, 8'h80);
    for (int v = 0; v < 16; v++) begin
      in_vec = v[3:0]; #1;
      check("R3 empty term", f_out, 4'h1);
    end

    // R2: code 11 on every input acts as left out; code 10/01 on input 0
    write_row(1'b0, 3'd7, 8'hFF);
    sweep("R2 reserved code");
    write_row(1'b0, 3'd6, 8'b00_00_00_10);
    write_row(1'b1, 3'd1, 8'h40);
    write_row(1'b0, 3'd5, 8'b00_00_00_01);
    write_row(1'b1, 3'd2, 8'h20);
    in_vec = 4'h1; #1; check("R2 true literal", f_out, 4'h3);
    in_vec = 4'h0; #1; check("R2 complement literal", f_out, 4'h5);

    // R4: output 3 has an empty row
    for (int v = 0; v < 16; v++) begin
      in_vec = v[3:0]; #1;
      check("R4 empty row", {3'b000, f_out[3]}, 4'h0);
    end

    // R7: out-of-range sum row and disabled writes change nothing
    write_row(1'b1, 3'd5, 8'hFF);
    write_row(1'b1, 3'd7, 8'hFF);
    sweep("R7 range ignore");
    @(negedge clk);
    cfg_we = 1'b0; cfg_plane = 1'b1; cfg_row = 3'd3; cfg_data = 8'hFF;
    repeat (2) @(posedge clk);
    #1;
    sweep("R7 no enable");

    // R9 first table: terms A'B', AC', B, BC', AC
    do_reset();
    write_row(1'b0, 3'd0, 8'h14);
    write_row(1'b0, 3'd1, 8'h21);
    write_row(1'b0, 3'd2, 8'h08);
    write_row(1'b0, 3'd3, 8'h09);
    write_row(1'b0, 3'd4, 8'h22);
    write_row(1'b1, 3'd0, 8'h03);
    write_row(1'b1, 3'd1, 8'h06);
    write_row(1'b1, 3'd2, 8'h09);
    write_row(1'b1, 3'd3, 8'h0C);
    for (int v = 0; v < 16; v++) begin
      in_vec = v[3:0]; #1;
      check("R9 table one", f_out, ex1(in_vec));
    end
    sweep("R5 shared terms");

    // R9 second table
    do_reset();
    write_row(1'b0, 3'd0, 8'h62);
    write_row(1'b0, 3'd1, 8'hA2);
    write_row(1'b0, 3'd2, 8'h94);
    write_row(1'b0, 3'd3, 8'h18);
    write_row(1'b0, 3'd4, 8'h08);
    write_row(1'b0, 3'd5, 8'h28);
    write_row(1'b1, 3'd1, 8'h0F);
    write_row(1'b1, 3'd2, 8'h11);
    write_row(1'b1, 3'd3, 8'h26);
    for (int v = 0; v < 16; v++) begin
      in_vec = v[3:0]; #1;
      check("R9 table two", f_out, ex2(in_vec));
    end

    // R8: input changes propagate with no clock edge in between
    @(negedge clk);
    in_vec = 4'h2; #1; check("R8 comb path", f_out, ex2(4'h2));
    in_vec = 4'h8; #1; check("R8 comb path", f_out, ex2(4'h8));

    // R6/R5/R7 random: new input and a write in the same cycle
    for (int k = 0; k < 600; k++) begin
      logic we, pl;
      logic [ROW_W-1:0] rw;
      logic [DATA_W-1:0] dt;
      we = ($urandom % 4) != 0;
      pl = $urandom % 2;
      rw = ROW_W'($urandom);
      dt = DATA_W'($urandom);
      @(negedge clk);
      cfg_we = we; cfg_plane = pl; cfg_row = rw; cfg_data = dt;
      in_vec = N_IN'($urandom);
      #1;
      check("R6 before edge", f_out, model_eval(in_vec));
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      if (we) model_write(pl, rw, dt);
      check(we ? "R6 after edge" : "R7 idle edge", f_out, model_eval(in_vec));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule